// File: doc/BRIEF.md
# DRAM Refresh Address Generator

This block produces the memory refresh slot that an 8-bit CPU bus interface inserts after every opcode fetch. It keeps an 8-bit refresh register. The low seven bits of that register form a counter that steps once for each opcode fetch, not once per clock. The top bit changes only when the instruction decoder loads the whole register.

Each fetch opens a refresh slot of a fixed number of cycles. For the length of the slot, the block drives the low address byte with the register value captured at the fetch. It also pulls both the refresh strobe and the memory-request strobe low, which dynamic memories read as a refresh request.

While the CPU is halted, the bus interface stops issuing fetch strobes. The block then paces its own internal no-operation fetches, so refresh continues at a steady rate.

Top module: `rfsh_addr_gen`

## Requirements
- R1: After reset, `r_value` is 0x00, `rfsh_n` and `mreq_n` are high and `addr_lo` is 0x00.
- R2: Each effective fetch adds one to `r_value[6:0]` on the following clock edge. `r_value[7]` never changes except through a register write.
- R3: When the count field is 127, the next fetch sets it to 0 and leaves bit 7 as it was. For example, 0x7F steps to 0x00 and 0xFF steps to 0x80.
- R4: During a refresh slot, `addr_lo` equals the value `r_value` had in the cycle of the fetch that opened the slot. Outside a slot, `addr_lo` is 0x00.
- R5: `rfsh_n` goes low in the first cycle after an effective fetch and stays low for exactly `SLOT_CYCLES` cycles, then returns high. It is never low outside such a window. A fetch that arrives inside a slot starts a new full-length slot.
- R6: `mreq_n` is low in exactly the cycles in which `rfsh_n` is low.
- R7: When `wr_en` is high, `r_value` takes `wr_data` on the next edge. This holds even if a fetch occurs in the same cycle, and that fetch's increment is then dropped. A slot opened by that fetch still shows the value the register had before the write.
- R8: While `halted` is high, `fetch_done` is ignored. An internal fetch occurs after every `NOP_PERIOD` consecutive halted cycles, and the first one comes after the first `NOP_PERIOD` halted cycles. Each internal fetch opens a slot and steps the counter exactly as an external fetch does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_done | input | 1 | One-cycle strobe marking the end of an opcode fetch |
| halted | input | 1 | High while the CPU sits in its halt state |
| wr_en | input | 1 | Loads the refresh register from `wr_data` |
| wr_data | input | 8 | Value for a register load |
| addr_lo | output | 8 | Low address byte during a refresh slot, zero otherwise |
| rfsh_n | output | 1 | Active-low refresh strobe |
| mreq_n | output | 1 | Active-low memory request for the refresh read |
| r_value | output | 8 | Current refresh register contents |

## Verification
A wrong counter value becomes visible on `r_value` on the edge after the faulty update. The same wrong value then reaches `addr_lo` in the next refresh slot, one fetch later. A slot timer in the wrong state shows up as a strobe that is too long, too short or misplaced, and the fault is visible in the first cycle after the fetch. A fault in the halt pacer shifts the first internal refresh away from cycle `NOP_PERIOD` of the halt, so the bench keeps long halt runs and compares every cycle against its own model.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  // Advance the 7-bit count field and keep the top bit unchanged.
  function automatic logic [7:0] rf_step(input logic [7:0] cur);
    rf_step = {cur[7], cur[6:0] + 7'd1};
  endfunction

endpackage

// File: rtl/rfsh_halt_pacer.sv
module rfsh_halt_pacer #(
  parameter int NOP_PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_done,
  input  logic halted,
  output logic fetch_eff
);
  localparam int HW = (NOP_PERIOD > 1) ? $clog2(NOP_PERIOD) : 1;
  localparam logic [HW-1:0] LAST = HW'(NOP_PERIOD - 1);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          tick;

  always_comb begin
    tick  = halted && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!halted)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + HW'(1);
    fetch_eff = halted ? tick : fetch_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (NOP_PERIOD > 1) begin : g_gap
      assert_halt_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && tick) |=> !tick);
    end
  endgenerate

  assert_halt_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !tick) |-> !fetch_eff);

endmodule

// File: rtl/rfsh_reg.sv
module rfsh_reg
  import refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_eff,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] r_q
);
  logic [7:0] r_d;
  logic       r_en;

  always_comb begin
    r_en = wr_en || fetch_eff;
    r_d  = wr_en ? wr_data : rf_step(r_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    r_q <= 8'h00;
    else if (r_en) r_q <= r_d;
  end

  assert_bit7_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (r_q[7] == $past(r_q[7])));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_eff && !wr_en) |=> (r_q[6:0] == $past(r_q[6:0]) + 7'd1));
  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (r_q == $past(wr_data)));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_eff && !wr_en && r_q[6:0] == 7'h7F) |=> (r_q[6:0] == 7'h00));

endmodule

// File: rtl/rfsh_slot.sv
module rfsh_slot #(
  parameter int SLOT_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_eff,
  input  logic [7:0] r_cur,
  output logic [7:0] addr_lo,
  output logic       slot_active
);
  localparam int SW = $clog2(SLOT_CYCLES + 1);
  localparam logic [SW-1:0] FULL = SW'(SLOT_CYCLES);

  logic [SW-1:0] left_q, left_d;
  logic [7:0]    lat_q;

  always_comb begin
    left_d = left_q;
    if (fetch_eff)          left_d = FULL;
    else if (left_q != '0)  left_d = left_q - SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat_q <= 8'h00;
    else if (fetch_eff) lat_q <= r_cur;
  end

  always_comb begin
    slot_active = (left_q != '0);
    addr_lo     = slot_active ? lat_q : 8'h00;
  end

  assert_slot_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_eff |=> slot_active);
  assert_slot_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_eff |=> (addr_lo == $past(r_cur)));

endmodule

// File: rtl/rfsh_addr_gen.sv
module rfsh_addr_gen #(
  parameter int SLOT_CYCLES = 2,
  parameter int NOP_PERIOD  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_done,
  input  logic       halted,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] addr_lo,
  output logic       rfsh_n,
  output logic       mreq_n,
  output logic [7:0] r_value
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       fetch_eff;
  logic       slot_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  rfsh_halt_pacer #(.NOP_PERIOD(NOP_PERIOD)) u_pacer (
    .clk(clk), .rst_n(rst_core_n), .fetch_done(fetch_done),
    .halted(halted), .fetch_eff(fetch_eff)
  );

  rfsh_reg u_reg (
    .clk(clk), .rst_n(rst_core_n), .fetch_eff(fetch_eff),
    .wr_en(wr_en), .wr_data(wr_data), .r_q(r_value)
  );

  rfsh_slot #(.SLOT_CYCLES(SLOT_CYCLES)) u_slot (
    .clk(clk), .rst_n(rst_core_n), .fetch_eff(fetch_eff),
    .r_cur(r_value), .addr_lo(addr_lo), .slot_active(slot_active)
  );

  assign rfsh_n = ~slot_active;
  assign mreq_n = ~slot_active;

  assert_idle_addr_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    rfsh_n |-> (addr_lo == 8'h00));
  assert_strobe_pair_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rfsh_n == mreq_n));

endmodule

// File: tb/rfsh_addr_gen_bench.sv
module rfsh_addr_gen_bench;
  localparam int SLOT = 2;
  localparam int NOPP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_done = 1'b0, halted = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] addr_lo, r_value;
  logic rfsh_n, mreq_n;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rfsh_addr_gen #(.SLOT_CYCLES(SLOT), .NOP_PERIOD(NOPP)) u_rfsh_addr_gen (
    .clk(clk), .rst_n(rst_n), .fetch_done(fetch_done), .halted(halted),
    .wr_en(wr_en), .wr_data(wr_data), .addr_lo(addr_lo), .rfsh_n(rfsh_n),
    .mreq_n(mreq_n), .r_value(r_value)
  );

  // Reference model built from the requirements
  logic [7:0] m_r = 8'h00, m_lat = 8'h00;
  int m_left = 0, m_hcnt = 0;

  function automatic logic [7:0] exp_step(input logic [7:0] v);
    return {v[7], 7'(v[6:0] + 7'd1)};
  endfunction

  function automatic logic exp_eff(input logic h, input logic f, input int hc);
    return h ? (hc == NOPP - 1) : f;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r <= 8'h00; m_lat <= 8'h00; m_left <= 0; m_hcnt <= 0;
    end else begin
      logic e;
      e = exp_eff(halted, fetch_done, m_hcnt);
      m_hcnt <= !halted ? 0 : (m_hcnt == NOPP - 1 ? 0 : m_hcnt + 1);
      if (wr_en) m_r <= wr_data;
      else if (e) m_r <= exp_step(m_r);
      if (e) begin m_lat <= m_r; m_left <= SLOT; end
      else if (m_left > 0) m_left <= m_left - 1;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    check("R2 r_value", r_value, m_r);
    check("R4 addr_lo", addr_lo, (m_left > 0) ? m_lat : 8'h00);
    check("R5 rfsh_n", {7'd0, rfsh_n}, {7'd0, m_left == 0});
    check("R6 mreq_n", {7'd0, mreq_n}, {7'd0, m_left == 0});
  endtask

  task automatic step(input logic f, input logic h, input logic w, input logic [7:0] d);
    fetch_done = f; halted = h; wr_en = w; wr_data = d;
    @(negedge clk);
    cmp_all();
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 r_value", r_value, 8'h00);
    check("R1 addr_lo", addr_lo, 8'h00);
    check("R1 rfsh_n", {7'd0, rfsh_n}, 8'h01);
    check("R1 mreq_n", {7'd0, mreq_n}, 8'h01);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, 8'h00);

    // R5: single fetch gives SLOT cycles of strobe, R4 address pre-increment
    step(1, 0, 0, 8'h00);
    check("R5 slot start", {7'd0, rfsh_n}, 8'h00);
    check("R4 slot addr", addr_lo, 8'h00);
    step(0, 0, 0, 8'h00);
    check("R5 slot second", {7'd0, rfsh_n}, 8'h00);
    step(0, 0, 0, 8'h00);
    check("R5 slot end", {7'd0, rfsh_n}, 8'h01);

    // R3: wrap with bit 7 clear and set
    step(0, 0, 1, 8'h7F);
    step(1, 0, 0, 8'h00);
    check("R3 wrap low", r_value, 8'h00);
    step(0, 0, 1, 8'hFF);
    step(1, 0, 0, 8'h00);
    check("R3 wrap high", r_value, 8'h80);
    check("R4 wrap addr", addr_lo, 8'hFF);

    // R7: write beats a same-cycle fetch; slot shows the old value
    step(0, 0, 1, 8'h25);
    step(1, 0, 1, 8'hC3);
    check("R7 write priority", r_value, 8'hC3);
    check("R7 slot old value", addr_lo, 8'h25);
    repeat (3) step(0, 0, 0, 8'h00);

    // R8: halted, fetch_done ignored, first internal fetch after NOPP cycles
    for (int i = 0; i < NOPP; i++) begin
      check("R8 no refresh yet", {7'd0, rfsh_n}, 8'h01);
      step(1, 1, 0, 8'h00);
    end
    check("R8 internal fetch", {7'd0, rfsh_n}, 8'h00);
    check("R8 step", r_value, 8'hC4);
    repeat (3 * NOPP) step(1, 1, 0, 8'h00);
    check("R8 steady pace", r_value, 8'hC7);
    step(0, 0, 0, 8'h00);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic f, w, h;
      f = ($urandom % 3) == 0;
      w = ($urandom % 17) == 0;
      h = halted;
      if (($urandom % 40) == 0) h = ~h;
      step(f, h, w, 8'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule